// File: doc/BRIEF.md
# Doubleword Shift Unit

This block shifts a 64-bit source value left or right and returns the 64-bit result. Three shift kinds are offered: a left shift that brings in zeros, a right shift that brings in zeros, and a right shift that copies the source sign bit into the vacated positions. Each kind comes in three amount forms. The first uses a 5-bit immediate field. The second uses that same field offset by 32, so that shifts of 32 to 63 can be encoded. The third takes the amount from a register operand, of which only the low six bits count.

A 4-bit select picks the kind and the form. The unit sits in the execute stage of a 64-bit integer pipeline. Decode supplies the immediate field, the register operand and the select. The result is captured in an output register with a synchronous active-low reset, and a parameter can remove that register to give a purely combinational path.

The select is split into two fields. Bits 3:2 give the amount form: 00 immediate, 01 immediate plus 32, 10 register, 11 unused. Bits 1:0 give the kind: 00 left with zero fill, 01 right with zero fill, 10 right with sign fill, 11 unused.

Top module: `dshift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes zero.
- R2: With the default configuration, `result` reflects the inputs that were present at the previous rising edge, which is a latency of one cycle.
- R3: Immediate form (select bits 3:2 = 00): the shift amount equals `sa_field`, in the range 0 to 31.
- R4: Plus-32 form (select bits 3:2 = 01): the shift amount is 32 plus `sa_field`. A field of 0 shifts by exactly 32 and a field of 31 shifts by 63.
- R5: Register form (select bits 3:2 = 10): the shift amount is `amt_reg[5:0]`, and bits 63:6 of `amt_reg` have no effect.
- R6: Kind 00 shifts left, and every vacated low-order bit is zero.
- R7: Kind 01 shifts right, and every vacated high-order bit is zero.
- R8: Kind 10 shifts right, and every vacated high-order bit equals bit 63 of `src`.
- R9: Any select with bits 1:0 = 11 or bits 3:2 = 11 gives a result of zero.
- R10: A shift amount of zero returns `src` unchanged for every valid kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Select: bits 3:2 give the amount form, bits 1:0 give the kind |
| src | input | 64 | Value to be shifted |
| sa_field | input | 5 | Immediate shift amount field |
| amt_reg | input | 64 | Register operand that supplies the variable amount |
| result | output | 64 | Shifted value, registered |

## Verification
The bench instantiates the unit with the default parameters: a data width of 64 and the output register present. With these values the plus-32 form reaches shifts of 32 to 63, the register form has a full 6-bit amount, and the result appears one clock after its inputs. The bench therefore covers the edges of every amount range, including the shift by exactly 32 and the shift by 63. It also uses register operands with junk in the upper bits, sources with the sign bit both set and clear, and all seven unused select codes.

// File: rtl/dshift_pkg.sv
// Package: dshift_pkg
// Holds the encoding of the operation select that the shift unit uses.
// Bits [3:2] of the select give the amount form and bits [1:0] give the shift kind.
package dshift_pkg;

    // Direction and fill rule of the shift.
    typedef enum logic [1:0] {
        KIND_LEFT_ZERO  = 2'b00,
        KIND_RIGHT_ZERO = 2'b01,
        KIND_RIGHT_SIGN = 2'b10,
        KIND_UNUSED     = 2'b11
    } shift_kind_e;

    // Where the shift amount comes from.
    typedef enum logic [1:0] {
        FORM_IMM      = 2'b00,
        FORM_IMM_HIGH = 2'b01,
        FORM_REG      = 2'b10,
        FORM_UNUSED   = 2'b11
    } amt_form_e;

    // Full select word: the form sits above the kind.
    typedef struct packed {
        amt_form_e   form;
        shift_kind_e kind;
    } shift_op_t;

endpackage

// File: rtl/dshift_amount_gen.sv
// Module: dshift_amount_gen
// Works out the shift amount from the selected form.
// The immediate form zero-extends the field. The high form sets the top amount
// bit, which adds half the data width to the field. The register form keeps
// only the low AMT_W bits of the register operand.
// Assumes DATA_W is a power of two, so IMM_W = AMT_W - 1.
module dshift_amount_gen #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int IMM_W = AMT_W - 1
) (
    input  dshift_pkg::amt_form_e form,
    input  logic [IMM_W-1:0]      sa_field,
    input  logic [DATA_W-1:0]     amt_reg,
    output logic [AMT_W-1:0]      amt,
    output logic                  form_ok
);
    import dshift_pkg::*;

    // Select the amount source and flag the unused form.
    always_comb begin
        amt     = '0;
        form_ok = 1'b1;
        case (form)
            FORM_IMM:      amt = {1'b0, sa_field};
            FORM_IMM_HIGH: amt = {1'b1, sa_field};
            FORM_REG:      amt = amt_reg[AMT_W-1:0];
            default: begin
                amt     = '0;
                form_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dshift_barrel_core.sv
// Module: dshift_barrel_core
// Logarithmic barrel shifter with AMT_W stages. Stage s moves the data by 2**s
// when bit s of the amount is set. A right shift reverses the operand, shifts
// it left and reverses the result again. Vacated positions take the fill bit.
// Assumes that amt is smaller than DATA_W, which holds by its width.
module dshift_barrel_core #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amt,
    input  logic              dir_right,
    input  logic              fill,
    output logic [DATA_W-1:0] shifted
);
    logic [DATA_W-1:0] reversed_in;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] reversed_out;
    logic [DATA_W-1:0] stg [0:AMT_W];

    genvar gi, gs;

    // Bit-reverse the operand so that a right shift becomes a left shift.
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_rev_in
            assign reversed_in[gi] = operand[DATA_W-1-gi];
        end
    endgenerate

    // Choose between the plain operand and the reversed operand.
    assign pre    = dir_right ? reversed_in : operand;
    assign stg[0] = pre;

    // One mux stage per bit of the amount. Each stage moves the data by a power of two.
    generate
        for (gs = 0; gs < AMT_W; gs++) begin : g_stage
            localparam int STEP = 2 ** gs;
            assign stg[gs+1] = amt[gs] ? {stg[gs][DATA_W-1-STEP:0], {STEP{fill}}}
                                       : stg[gs];
        end
    endgenerate

    // Reverse the output of the left shifter again for right shifts.
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_rev_out
            assign reversed_out[gi] = stg[AMT_W][DATA_W-1-gi];
        end
    endgenerate

    // Put the result back in its original bit order.
    assign shifted = dir_right ? reversed_out : stg[AMT_W];

endmodule

// File: rtl/dshift_unit.sv
// Module: dshift_unit
// Top of the doubleword shift unit. It decodes the select, forms the amount,
// runs the barrel core and puts the result through an optional output
// register (OUT_REG = 1) with a synchronous active-low reset.
// An unused kind or form gives zero. Assumes DATA_W is a power of two
// and is at least 4.
module dshift_unit #(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int AMT_W  = $clog2(DATA_W),
    localparam int IMM_W  = AMT_W - 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] src,
    input  logic [IMM_W-1:0]  sa_field,
    input  logic [DATA_W-1:0] amt_reg,
    output logic [DATA_W-1:0] result
);
    import dshift_pkg::*;

    shift_op_t         op;
    logic [AMT_W-1:0]  amt;
    logic              form_ok;
    logic              kind_ok;
    logic              dir_right;
    logic              fill_bit;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] next_result;

    assign op = shift_op_t'(op_sel);

    // Decode the kind into a direction, a fill bit and a valid flag.
    always_comb begin
        kind_ok   = (op.kind != KIND_UNUSED);
        dir_right = (op.kind == KIND_RIGHT_ZERO) || (op.kind == KIND_RIGHT_SIGN);
        fill_bit  = (op.kind == KIND_RIGHT_SIGN) ? src[DATA_W-1] : 1'b0;
    end

    dshift_amount_gen #(.DATA_W(DATA_W)) u_amt (
        .form     (op.form),
        .sa_field (sa_field),
        .amt_reg  (amt_reg),
        .amt      (amt),
        .form_ok  (form_ok)
    );

    dshift_barrel_core #(.DATA_W(DATA_W)) u_core (
        .operand   (src),
        .amt       (amt),
        .dir_right (dir_right),
        .fill      (fill_bit),
        .shifted   (core_out)
    );

    // Force the result to zero for unused select codes.
    assign next_result = (kind_ok && form_ok) ? core_out : '0;

    generate
        if (OUT_REG) begin : g_reg
            // Output register with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) result <= '0;
                else        result <= next_result;
            end

            // R1: reset clears the result
            assert_reset_clear_R1: assert property (@(posedge clk)
                !rst_n |=> (result == '0));

            // R9: unused kind or form gives zero
            assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && ((op_sel[1:0] == 2'b11) || (op_sel[3:2] == 2'b11)))
                |=> (result == '0));

            // R10: immediate amount of zero returns the source unchanged
            assert_zero_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && (op_sel[3:2] == 2'b00) && (op_sel[1:0] != 2'b11) && (sa_field == '0))
                |=> (result == $past(src)));

            // R4: high-form left shift clears the whole low half
            assert_high_left_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && (op_sel == 4'b0100))
                |=> (result[HALF_W-1:0] == '0));

            // R7: high-form logical right shift clears the whole upper half
            assert_high_right_up_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && (op_sel == 4'b0101))
                |=> (result[DATA_W-1:HALF_W] == '0));

            // R8: high-form sign shift fills the whole upper half with the sign bit
            assert_high_sign_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && (op_sel == 4'b0110))
                |=> (result[DATA_W-1:HALF_W] == {HALF_W{$past(src[DATA_W-1])}}));

            // R5: a register operand whose low bits are zero passes the source through
            assert_reg_zero_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && (op_sel[3:2] == 2'b10) && (op_sel[1:0] != 2'b11)
                       && (amt_reg[AMT_W-1:0] == '0))
                |=> (result == $past(src)));
        end else begin : g_comb
            // Combinational variant: the decoded result goes straight to the output.
            assign result = next_result;
        end
    endgenerate

endmodule

// File: tb/dshift_unit_test.sv
// Scoreboard bench for dshift_unit. A driver task applies each operation on the
// falling edge and queues its expected value, which comes from the native
// SystemVerilog shift operators. A monitor compares after each rising edge.
module dshift_unit_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_sel = 4'h0;
    logic [W-1:0] src = '0;
    logic [4:0]   sa_field = '0;
    logic [W-1:0] amt_reg = '0;
    logic [W-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;
    item_t sb_q [$];

    always #4 clk = ~clk; // 125 MHz

    dshift_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src(src),
        .sa_field(sa_field), .amt_reg(amt_reg), .result(result)
    );

    // Reference model built from the requirements.
    function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] s,
                                           input logic [4:0] sa, input logic [W-1:0] ar);
        int n;
        case (op[3:2])
            2'b00: n = int'(sa);
            2'b01: n = 32 + int'(sa);
            2'b10: n = int'(ar[5:0]);
            default: return '0;
        endcase
        case (op[1:0])
            2'b00: return s << n;
            2'b01: return s >> n;
            2'b10: return W'($signed(s) >>> n);
            default: return '0;
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [W-1:0] s, input logic [4:0] sa,
                         input logic [W-1:0] ar, input string tag);
        item_t it;
        @(negedge clk);
        op_sel = op; src = s; sa_field = sa; amt_reg = ar;
        it.exp = model(op, s, sa, ar);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each queued result one time unit after the capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (result !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [W-1:0] NEG = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [W-1:0] POS = 64'h7123_4567_89AB_CDEF;
    localparam logic [W-1:0] JUNK_HI = 64'hFFFF_FFFF_FFFF_FFC0;

    initial begin
        src = NEG;
        repeat (3) @(negedge clk);
        n_tests++;
        if (result !== '0) begin
            n_fail++;
            $display("FAIL R1: got %h expected %h", result, 64'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Latency and immediate forms
        drive(4'b0000, POS, 5'd4, '0, "R2_R3_R6 imm left 4");
        drive(4'b0001, NEG, 5'd31, '0, "R3_R7 imm lright 31");
        drive(4'b0010, NEG, 5'd17, '0, "R3_R8 imm aright neg 17");
        drive(4'b0010, POS, 5'd9, '0, "R8 imm aright pos 9");
        // Zero amounts
        drive(4'b0000, NEG, 5'd0, '0, "R10 left zero");
        drive(4'b0001, NEG, 5'd0, '0, "R10 lright zero");
        drive(4'b0010, NEG, 5'd0, '0, "R10 aright zero");
        // Plus-32 forms
        drive(4'b0100, NEG, 5'd0, '0, "R4_R6 hi left 32");
        drive(4'b0101, NEG, 5'd0, '0, "R4_R7 hi lright 32");
        drive(4'b0110, NEG, 5'd31, '0, "R4_R8 hi aright 63");
        drive(4'b0110, POS, 5'd31, '0, "R4_R8 hi aright pos 63");
        drive(4'b0100, NEG, 5'd31, '0, "R4 hi left 63");
        drive(4'b0101, NEG, 5'd31, '0, "R4 hi lright 63");
        // Register forms with junk upper bits
        drive(4'b1000, POS, 5'd7, JUNK_HI | 64'd13, "R5 reg left 13");
        drive(4'b1001, NEG, 5'd7, JUNK_HI | 64'd40, "R5 reg lright 40");
        drive(4'b1010, NEG, 5'd7, JUNK_HI | 64'd63, "R5 reg aright 63");
        drive(4'b1010, NEG, 5'd7, JUNK_HI, "R5_R10 reg zero low");
        // Unused codes
        drive(4'b0011, NEG, 5'd3, '0, "R9 op 3");
        drive(4'b0111, NEG, 5'd3, '0, "R9 op 7");
        drive(4'b1011, NEG, 5'd3, 64'd2, "R9 op 11");
        for (int k = 12; k < 16; k++)
            drive(4'(k), NEG, 5'd3, 64'd2, "R9 form unused");
        // Many immediate and register amounts
        for (int a = 0; a < 64; a++) begin
            drive(4'b1000, NEG, 5'(a), 64'(a), "R5_R6 sweep left");
            drive(4'b1001, NEG, 5'(a), 64'(a), "R5_R7 sweep lright");
            drive(4'b1010, NEG, 5'(a), 64'(a), "R5_R8 sweep aright");
        end
        // Reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0; op_sel = 4'b0000; src = NEG; sa_field = 5'd0;
        @(negedge clk);
        n_tests++;
        if (result !== '0) begin
            n_fail++;
            $display("FAIL R1: got %h expected %h", result, 64'h0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule